// File: doc/BRIEF.md
# Time-of-Day Counter Core

This block keeps wall-clock time from a fast free-running system clock. A prescaler counts system clock cycles modulo the clock frequency in hertz and marks one cycle in every second. In that cycle the seconds counter advances. The minutes and hours counters advance only on the exact edge on which the stage below them wraps to zero. The carry into a stage is the lower stage's last value ANDed with the prescaler tick. It is never a level test on the lower count being zero, because such a test would stay true for a whole second.

The core gives binary seconds, minutes and hours. It also gives a tens digit and a units digit for each value, ready for a seven-segment decoder placed after it. The tick cycle is also an output, so that logic downstream can line up with each second. The `CLK_HZ` parameter defaults to 50 MHz. Setting it to 50 (or lower, down to 2) shortens simulation without changing the behaviour.

Top module: `tod_counter`

## Requirements
- R1: While `rst` is sampled high on an edge, the prescaler and all three time counters are cleared to 0 on that edge, and `sec_tick` is low in every cycle in which `rst` is high.
- R2: `sec_tick` is high in exactly one cycle out of every `CLK_HZ` cycles. The first tick is the first cycle after reset is released, and a tick never lasts two consecutive cycles.
- R3: On the edge that ends a `sec_tick` cycle, `sec_bin` increases by one (below 59). On every other edge it holds its value.
- R4: When `sec_bin` is 59 in a tick cycle, it becomes 0 on the next edge.
- R5: `min_bin` increases by one on the same edge on which `sec_bin` goes from 59 to 0, and it changes on no other edge.
- R6: `min_bin` wraps from 59 to 0 on the edge on which seconds wrap from 59. `hr_bin` increases on that same edge and on no other.
- R7: `hr_bin` stays within 0 to 23. The time 23:59:59 becomes 00:00:00 on a single edge.
- R8: For each of seconds, minutes and hours, the tens output equals the binary value divided by 10 and the units output equals the value modulo 10. Both are combinational and valid in the same cycle as the binary value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, `CLK_HZ` hertz |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | output | 1 | High for the one cycle per second in which time advances |
| sec_bin | output | 6 | Seconds, 0 to 59 |
| min_bin | output | 6 | Minutes, 0 to 59 |
| hr_bin | output | 5 | Hours, 0 to 23 |
| sec_tens | output | 4 | Tens digit of seconds |
| sec_ones | output | 4 | Units digit of seconds |
| min_tens | output | 4 | Tens digit of minutes |
| min_ones | output | 4 | Units digit of minutes |
| hr_tens | output | 4 | Tens digit of hours |
| hr_ones | output | 4 | Units digit of hours |

## Verification
The tick is combinational from the prescaler, so it is due in the same cycle that the prescaler reads zero. That includes the very first cycle after reset release. The binary counts are due one edge after their tick cycle, and the digit outputs are due in the same cycle as the binary value. After the release edge, after k edges the total seconds elapsed is floor((k + CLK_HZ - 1) / CLK_HZ), and a tick is present when k is a multiple of `CLK_HZ`. The bench counts edges from release, derives each expected value from that formula, and samples 2 ns after a rising edge. A second instance with `CLK_HZ` = 2 runs alongside the 50 Hz instance so that a full day fits in the run.

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic       clk,
  input  logic       rst,
  output logic       sec_tick,
  output logic [5:0] sec_bin,
  output logic [5:0] min_bin,
  output logic [4:0] hr_bin,
  output logic [3:0] sec_tens,
  output logic [3:0] sec_ones,
  output logic [3:0] min_tens,
  output logic [3:0] min_ones,
  output logic [3:0] hr_tens,
  output logic [3:0] hr_ones
);
  localparam int PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1;
  localparam logic [PW-1:0] PMAX = PW'(CLK_HZ - 1);
  localparam logic [5:0] SEC_LAST = 6'd59;
  localparam logic [5:0] MIN_LAST = 6'd59;
  localparam logic [4:0] HR_LAST  = 5'd23;

  logic [PW-1:0] pre;
  logic sec_wrap, min_wrap;

  assign sec_tick = (pre == '0) && !rst;
  assign sec_wrap = sec_tick && (sec_bin == SEC_LAST);
  assign min_wrap = sec_wrap && (min_bin == MIN_LAST);

  always_ff @(posedge clk) begin
    if (rst)              pre <= '0;
    else if (pre == PMAX) pre <= '0;
    else                  pre <= pre + PW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)           sec_bin <= '0;
    else if (sec_wrap) sec_bin <= '0;
    else if (sec_tick) sec_bin <= sec_bin + 6'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)           min_bin <= '0;
    else if (min_wrap) min_bin <= '0;
    else if (sec_wrap) min_bin <= min_bin + 6'd1;
  end

  always_ff @(posedge clk) begin
    if (rst)                                  hr_bin <= '0;
    else if (min_wrap && hr_bin == HR_LAST)   hr_bin <= '0;
    else if (min_wrap)                        hr_bin <= hr_bin + 5'd1;
  end

  function automatic logic [3:0] tens_of(input logic [5:0] v);
    return 4'(v / 6'd10);
  endfunction

  function automatic logic [3:0] ones_of(input logic [5:0] v);
    return 4'(v % 6'd10);
  endfunction

  assign sec_tens = tens_of(sec_bin);
  assign sec_ones = ones_of(sec_bin);
  assign min_tens = tens_of(min_bin);
  assign min_ones = ones_of(min_bin);
  assign hr_tens  = tens_of({1'b0, hr_bin});
  assign hr_ones  = ones_of({1'b0, hr_bin});
endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       sec_tick,
  input logic [5:0] sec_bin,
  input logic [5:0] min_bin,
  input logic [4:0] hr_bin,
  input logic [3:0] sec_tens,
  input logic [3:0] sec_ones,
  input logic [3:0] min_tens,
  input logic [3:0] min_ones,
  input logic [3:0] hr_tens,
  input logic [3:0] hr_ones
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (sec_bin == 6'd0 && min_bin == 6'd0 && hr_bin == 5'd0));
  a_r1_no_tick_in_reset: assert property (@(posedge clk)
    rst |-> !sec_tick);
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> !sec_tick);
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !sec_tick |=> $stable(sec_bin));
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && sec_bin != 6'd59) |=> (sec_bin == $past(sec_bin) + 6'd1));
  a_r4_sec_wrap: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && sec_bin == 6'd59) |=> (sec_bin == 6'd0));
  a_r5_min_hold: assert property (@(posedge clk) disable iff (rst)
    !(sec_tick && sec_bin == 6'd59) |=> $stable(min_bin));
  a_r5_min_step: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && sec_bin == 6'd59 && min_bin != 6'd59) |=> (min_bin == $past(min_bin) + 6'd1));
  a_r6_hr_hold: assert property (@(posedge clk) disable iff (rst)
    !(sec_tick && sec_bin == 6'd59 && min_bin == 6'd59) |=> $stable(hr_bin));
  a_r6_min_wrap: assert property (@(posedge clk) disable iff (rst)
    (sec_tick && sec_bin == 6'd59 && min_bin == 6'd59) |=> (min_bin == 6'd0));
  a_r7_hr_range: assert property (@(posedge clk) disable iff (rst)
    hr_bin <= 5'd23);
  a_r8_sec_digits: assert property (@(posedge clk) disable iff (rst)
    (sec_ones <= 4'd9) && ({2'b0, sec_tens} * 6'd10 + {2'b0, sec_ones} == sec_bin));
  a_r8_min_digits: assert property (@(posedge clk) disable iff (rst)
    (min_ones <= 4'd9) && ({2'b0, min_tens} * 6'd10 + {2'b0, min_ones} == min_bin));
  a_r8_hr_digits: assert property (@(posedge clk) disable iff (rst)
    (hr_ones <= 4'd9) && ({1'b0, hr_tens} * 5'd10 + {1'b0, hr_ones} == hr_bin));
endmodule

bind tod_counter tod_counter_chk u_chk (
  .clk(clk), .rst(rst), .sec_tick(sec_tick),
  .sec_bin(sec_bin), .min_bin(min_bin), .hr_bin(hr_bin),
  .sec_tens(sec_tens), .sec_ones(sec_ones),
  .min_tens(min_tens), .min_ones(min_ones),
  .hr_tens(hr_tens), .hr_ones(hr_ones)
);

// File: tb/tb_tod_counter.sv
`timescale 1ns/1ps
module tb_tod_counter;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       tk [2];
  logic [5:0] sb [2];
  logic [5:0] mb [2];
  logic [4:0] hb [2];
  logic [3:0] st [2], so [2], mt [2], mo [2], ht [2], ho [2];

  tod_counter #(.CLK_HZ(50)) dut (
    .clk(clk), .rst(rst), .sec_tick(tk[0]),
    .sec_bin(sb[0]), .min_bin(mb[0]), .hr_bin(hb[0]),
    .sec_tens(st[0]), .sec_ones(so[0]), .min_tens(mt[0]), .min_ones(mo[0]),
    .hr_tens(ht[0]), .hr_ones(ho[0]));

  tod_counter #(.CLK_HZ(2)) dut_fast (
    .clk(clk), .rst(rst), .sec_tick(tk[1]),
    .sec_bin(sb[1]), .min_bin(mb[1]), .hr_bin(hb[1]),
    .sec_tens(st[1]), .sec_ones(so[1]), .min_tens(mt[1]), .min_ones(mo[1]),
    .hr_tens(ht[1]), .hr_ones(ho[1]));

  int total = 0;
  int bad = 0;

  typedef struct packed {
    int k; int inst; int tick; int h; int m; int s; logic [31:0] tag;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{0,      0, 1, 0,  0,  0,  "R2"},
    '{1,      0, 0, 0,  0,  1,  "R3"},
    '{49,     0, 0, 0,  0,  1,  "R3"},
    '{50,     0, 1, 0,  0,  1,  "R2"},
    '{51,     0, 0, 0,  0,  2,  "R3"},
    '{1801,   0, 0, 0,  0,  37, "R8"},
    '{2950,   0, 1, 0,  0,  59, "R5"},
    '{2951,   0, 0, 0,  1,  0,  "R4"},
    '{3000,   0, 1, 0,  1,  0,  "R5"},
    '{3001,   0, 0, 0,  1,  1,  "R5"},
    '{7197,   1, 0, 0,  59, 59, "R6"},
    '{7198,   1, 1, 0,  59, 59, "R6"},
    '{7199,   1, 0, 1,  0,  0,  "R6"},
    '{172797, 1, 0, 23, 59, 59, "R7"},
    '{172798, 1, 1, 23, 59, 59, "R7"},
    '{172799, 1, 0, 0,  0,  0,  "R7"}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_time(input string req, input int i, input int tick, input int h,
                          input int m, input int s);
    chk({req, " tick"}, int'(tk[i]), tick);
    chk({req, " sec"}, int'(sb[i]), s);
    chk({req, " min"}, int'(mb[i]), m);
    chk({req, " hr"}, int'(hb[i]), h);
    chk("R8 sec_tens", int'(st[i]), s / 10);
    chk("R8 sec_ones", int'(so[i]), s % 10);
    chk("R8 min_tens", int'(mt[i]), m / 10);
    chk("R8 min_ones", int'(mo[i]), m % 10);
    chk("R8 hr_tens", int'(ht[i]), h / 10);
    chk("R8 hr_ones", int'(ho[i]), h % 10);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cur;
    int ticks;
    repeat (3) @(posedge clk);
    #2;
    for (int i = 0; i < 2; i++) chk_time("R1", i, 0, 0, 0, 0);
    @(negedge clk);
    rst = 1'b0;
    cur = 0;
    #2;
    for (int v = 0; v < NV; v++) begin
      while (cur < VEC[v].k) begin
        @(posedge clk);
        cur++;
        #2;
      end
      chk_time(string'(VEC[v].tag), VEC[v].inst, VEC[v].tick, VEC[v].h, VEC[v].m, VEC[v].s);
    end

    // R1: reset in mid-run clears both instances on one edge
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    for (int i = 0; i < 2; i++) chk_time("R1", i, 0, 0, 0, 0);
    @(negedge clk);
    rst = 1'b0;
    #2;
    chk("R2 first tick after release", int'(tk[0]), 1);
    @(posedge clk);
    #2;
    chk("R3 first second", int'(sb[0]), 1);
    chk("R2 tick ends", int'(tk[0]), 0);
    ticks = 0;
    for (int c = 0; c < 100; c++) begin
      @(posedge clk);
      #2;
      if (tk[0]) ticks++;
    end
    chk("R2 ticks per 100 cycles", ticks, 2);
    chk("R3 seconds after 101 edges", int'(sb[0]), 3);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule